// File: doc/BRIEF.md
# Acquisition Time Base Sequencer

This block sequences one acquisition of a sampling instrument. It runs from the reference clock. A programmable divider turns that clock into a one-cycle sample strobe. After a start, the block first takes a programmed number of pre-trigger samples and then raises an arm output. One of four trigger sources is selected. Its first rising edge while armed is accepted as the trigger. The block then counts post-trigger samples, stops the sample strobe and holds a done flag for the host.

On the accepted trigger the block also raises an interval pulse. The pulse stays high until the next sample strobe. An external fine interpolator can measure the pulse to place the trigger between two samples. The host drives the divider ratio, both counts and the source select as static inputs, and starts each acquisition with a one-cycle start pulse.

Top module: `acq_timebase`

## Requirements
- R1: While reset is active, and after its release until a start is accepted, the outputs sample_en_o, arm_o, trig_seen_o, done_o and interp_pulse_o are all low.
- R2: During an acquisition, sample_en_o is high for exactly one cycle in every N cycles, where N is the divider ratio. The first strobe falls N-1 cycles after the first cycle following the accepted start. A ratio of 0 behaves as 1.
- R3: With a pre-trigger count P > 0, arm_o rises in the cycle after the P-th sample strobe. With P = 0, arm_o rises in the second cycle after the start is accepted.
- R4: trig_sel_i picks the trigger source: 0 selects trig_ch_a_i, 1 selects trig_ch_b_i, 2 selects trig_bus_i and 3 selects trig_ext_i. Edges on unselected sources have no effect.
- R5: Each trigger input passes through a two-stage synchronizer. A rising edge of the selected source that is first high at clock edge k is accepted at edge k+2, but only if arm_o is high in that cycle. trig_seen_o rises in the cycle after acceptance. Edges that occur before arm_o rises are ignored.
- R6: On acceptance, arm_o falls. Later edges of any source are ignored until the next start.
- R7: interp_pulse_o rises together with trig_seen_o. It stays high up to and including the next cycle with sample_en_o high, then falls. A strobe in the acceptance cycle itself does not end the pulse.
- R8: With a post-trigger count Q, done_o rises in the cycle after the (Q+1)-th sample strobe that follows acceptance. From then on, sample_en_o stays low.
- R9: done_o and trig_seen_o hold until the next start. start_i is honoured only when idle or done. A start during pre-trigger, armed or post-trigger phases is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle acquisition start |
| div_ratio_i | input | DIV_W | Sample divider ratio N (0 acts as 1) |
| pre_count_i | input | CNT_W | Pre-trigger sample count P |
| post_count_i | input | CNT_W | Post-trigger count Q |
| trig_sel_i | input | 2 | Trigger source select |
| trig_ch_a_i | input | 1 | Channel A comparator trigger |
| trig_ch_b_i | input | 1 | Channel B comparator trigger |
| trig_bus_i | input | 1 | Inter-module bus trigger |
| trig_ext_i | input | 1 | External trigger input |
| sample_en_o | output | 1 | Sample strobe |
| arm_o | output | 1 | Armed, waiting for trigger |
| trig_seen_o | output | 1 | Trigger accepted |
| done_o | output | 1 | Acquisition complete |
| interp_pulse_o | output | 1 | Trigger-to-next-strobe interval pulse |

## Verification
Two events can land in the same cycle: the sample strobe that ends the interval pulse and the strobe that meets the post-trigger terminal count. With Q = 0 they are the same strobe. A run with Q = 0 makes the pulse fall and done rise on one clock edge. The scoreboard expects both events in the same cycle and checks the pulse-width item before the done item. A second overlap is a strobe in the very cycle the trigger is accepted. It is provoked by using ratio 1, where every cycle strobes. There the pulse must still last one full strobe period instead of being cut to zero.

// File: rtl/acq_pkg.sv
package acq_pkg;
  localparam int unsigned NUM_SRC = 4;
  localparam int unsigned SEL_W   = $clog2(NUM_SRC);

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PRE   = 3'd1,
    ST_ARMED = 3'd2,
    ST_POST  = 3'd3,
    ST_DONE  = 3'd4
  } acq_state_e;

  // source order is the select encoding
  localparam int unsigned SRC_CH_A = 0;
  localparam int unsigned SRC_CH_B = 1;
  localparam int unsigned SRC_BUS  = 2;
  localparam int unsigned SRC_EXT  = 3;
endpackage

// File: rtl/acq_rate_div.sv
module acq_rate_div #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] ratio_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] limit;

  assign limit  = (ratio_i == '0) ? '0 : ratio_i - DIV_W'(1);
  assign tick_o = run_i && (cnt_q >= limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + DIV_W'(1);
  end
endmodule

// File: rtl/acq_trig_front.sv
module acq_trig_front
  import acq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [SEL_W-1:0]   sel_i,
  output logic               rise_o
);
  logic [NUM_SRC-1:0] lvl;
  logic               sel_lvl;
  logic               prev_q;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_sync
    logic [SYNC_STAGES-1:0] sh_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q <= '0;
      else         sh_q <= {sh_q[SYNC_STAGES-2:0], src_i[g]};
    end
    assign lvl[g] = sh_q[SYNC_STAGES-1];
  end

  assign sel_lvl = lvl[sel_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sel_lvl;
  end

  assign rise_o = sel_lvl & ~prev_q;
endmodule

// File: rtl/acq_seq.sv
module acq_seq
  import acq_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             tick_i,
  input  logic             rise_i,
  input  logic [CNT_W-1:0] pre_count_i,
  input  logic [CNT_W-1:0] post_count_i,
  output logic             run_o,
  output logic             arm_o,
  output logic             seen_o,
  output logic             done_o,
  output logic             pulse_o
);
  acq_state_e       state_q, state_d;
  logic [CNT_W-1:0] pre_q, pre_d, post_q, post_d;
  logic [CNT_W-1:0] pre_inc;
  logic             seen_q, seen_d, pulse_q, pulse_d;

  assign pre_inc = pre_q + CNT_W'(1);

  always_comb begin
    state_d = state_q;
    pre_d   = pre_q;
    post_d  = post_q;
    seen_d  = seen_q;
    pulse_d = pulse_q;
    if (pulse_q && tick_i) pulse_d = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_DONE: begin
        if (start_i) begin
          state_d = ST_PRE;
          pre_d   = '0;
          post_d  = '0;
          seen_d  = 1'b0;
          pulse_d = 1'b0;
        end
      end
      ST_PRE: begin
        if (pre_count_i == '0) begin
          state_d = ST_ARMED;
        end else if (tick_i) begin
          pre_d = pre_inc;
          if (pre_inc >= pre_count_i) state_d = ST_ARMED;
        end
      end
      ST_ARMED: begin
        if (rise_i) begin
          state_d = ST_POST;
          seen_d  = 1'b1;
          pulse_d = 1'b1; // a strobe in this cycle does not end the pulse
        end
      end
      ST_POST: begin
        if (tick_i) begin
          if (post_q == post_count_i) state_d = ST_DONE;
          else                        post_d  = post_q + CNT_W'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pre_q   <= '0;
      post_q  <= '0;
      seen_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      state_q <= state_d;
      pre_q   <= pre_d;
      post_q  <= post_d;
      seen_q  <= seen_d;
      pulse_q <= pulse_d;
    end
  end

  assign run_o   = (state_q == ST_PRE) || (state_q == ST_ARMED) || (state_q == ST_POST);
  assign arm_o   = (state_q == ST_ARMED);
  assign done_o  = (state_q == ST_DONE);
  assign seen_o  = seen_q;
  assign pulse_o = pulse_q;
endmodule

// File: rtl/acq_timebase.sv
module acq_timebase
  import acq_pkg::*;
#(
  parameter int unsigned DIV_W = 16,
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [DIV_W-1:0] div_ratio_i,
  input  logic [CNT_W-1:0] pre_count_i,
  input  logic [CNT_W-1:0] post_count_i,
  input  logic [SEL_W-1:0] trig_sel_i,
  input  logic             trig_ch_a_i,
  input  logic             trig_ch_b_i,
  input  logic             trig_bus_i,
  input  logic             trig_ext_i,
  output logic             sample_en_o,
  output logic             arm_o,
  output logic             trig_seen_o,
  output logic             done_o,
  output logic             interp_pulse_o
);
  logic               run, tick, rise;
  logic [NUM_SRC-1:0] src;

  assign src[SRC_CH_A] = trig_ch_a_i;
  assign src[SRC_CH_B] = trig_ch_b_i;
  assign src[SRC_BUS]  = trig_bus_i;
  assign src[SRC_EXT]  = trig_ext_i;

  acq_rate_div #(.DIV_W(DIV_W)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run),
    .ratio_i (div_ratio_i),
    .tick_o  (tick)
  );

  acq_trig_front #(.SYNC_STAGES(2)) u_trig (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .src_i  (src),
    .sel_i  (trig_sel_i),
    .rise_o (rise)
  );

  acq_seq #(.CNT_W(CNT_W)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .tick_i       (tick),
    .rise_i       (rise),
    .pre_count_i  (pre_count_i),
    .post_count_i (post_count_i),
    .run_o        (run),
    .arm_o        (arm_o),
    .seen_o       (trig_seen_o),
    .done_o       (done_o),
    .pulse_o      (interp_pulse_o)
  );

  assign sample_en_o = tick;
endmodule

// File: rtl/acq_timebase_chk.sv
module acq_timebase_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic sample_en_o,
  input logic arm_o,
  input logic trig_seen_o,
  input logic done_o,
  input logic interp_pulse_o
);
  p_no_strobe_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !sample_en_o);

  p_done_after_strobe_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(sample_en_o));

  p_arm_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(arm_o && trig_seen_o));

  p_accept_armed_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(trig_seen_o) |-> $past(arm_o));

  p_pulse_with_trig_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(interp_pulse_o) |-> $rose(trig_seen_o));

  p_pulse_end_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (interp_pulse_o && sample_en_o) |=> !interp_pulse_o);

  p_done_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> (done_o && trig_seen_o));
endmodule

bind acq_timebase acq_timebase_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .start_i        (start_i),
  .sample_en_o    (sample_en_o),
  .arm_o          (arm_o),
  .trig_seen_o    (trig_seen_o),
  .done_o         (done_o),
  .interp_pulse_o (interp_pulse_o)
);

// File: tb/acq_timebase_test.sv
`timescale 1ns/1ps
module acq_timebase_test;
  localparam int EV_ARM = 0, EV_TRIG = 1, EV_PW = 2, EV_DONE = 3;

  typedef struct {int kind; int val;} exp_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] div_ratio_i = 16'd1;
  logic [15:0] pre_count_i = '0;
  logic [15:0] post_count_i = '0;
  logic [1:0]  trig_sel_i = '0;
  logic [3:0]  src_drv = '0;
  logic        sample_en_o, arm_o, trig_seen_o, done_o, interp_pulse_o;

  exp_t exp_q[$];
  int   n_chk = 0, n_err = 0;
  int   rel = 0, nstb = 0, pw = 0, last_stb = -1, cur_neff = 1;
  bit   restart_flag = 0;
  bit   arm_d = 0, trig_d = 0, pulse_d = 0, done_d = 0;
  string req_of[4] = '{"R3", "R5", "R7", "R8"};

  always #4 clk_i = ~clk_i;

  acq_timebase uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .div_ratio_i(div_ratio_i), .pre_count_i(pre_count_i), .post_count_i(post_count_i),
    .trig_sel_i(trig_sel_i),
    .trig_ch_a_i(src_drv[0]), .trig_ch_b_i(src_drv[1]),
    .trig_bus_i(src_drv[2]), .trig_ext_i(src_drv[3]),
    .sample_en_o(sample_en_o), .arm_o(arm_o), .trig_seen_o(trig_seen_o),
    .done_o(done_o), .interp_pulse_o(interp_pulse_o)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic take_evt(int kind, int val);
    exp_t e;
    if (exp_q.size() == 0) begin
      chk(0, req_of[kind], val, -1);
    end else begin
      e = exp_q.pop_front();
      chk(e.kind == kind, req_of[e.kind], kind, e.kind);
      if (e.kind == kind) chk(e.val == val, req_of[kind], val, e.val);
    end
  endtask

  // monitor: samples mid-cycle, relative cycle 0 is the first cycle after start is taken
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (start_i && restart_flag) begin
        rel = -1; nstb = 0; pw = 0; last_stb = -1;
      end else rel++;
      if (sample_en_o && rel >= 0) begin
        nstb++;
        if (last_stb < 0) chk(rel == cur_neff - 1, "R2", rel, cur_neff - 1);
        else              chk(rel - last_stb == cur_neff, "R2", rel - last_stb, cur_neff);
        last_stb = rel;
      end
      if (arm_o && !arm_d)         take_evt(EV_ARM, rel);
      if (trig_seen_o && !trig_d)  take_evt(EV_TRIG, rel);
      if (interp_pulse_o) pw++;
      else if (pulse_d) begin take_evt(EV_PW, pw); pw = 0; end
      if (done_o && !done_d)       take_evt(EV_DONE, rel);
      arm_d = arm_o; trig_d = trig_seen_o; pulse_d = interp_pulse_o; done_d = done_o;
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk_i);
    #2;
  endtask

  // flav: 1 = unselected sources toggle, 2 = selected pulse before arm, 4 = re-edge and start while running
  task automatic run_case(int n, int p, int q, int sel, int dly, int flav);
    int neff, ct, s1, sq, exp_n;
    neff = (n == 0) ? 1 : n;
    tick(1);
    div_ratio_i = 16'(n); pre_count_i = 16'(p); post_count_i = 16'(q);
    trig_sel_i = 2'(sel); src_drv = '0; cur_neff = neff;
    tick(3);
    exp_q.push_back('{EV_ARM, (p == 0) ? 1 : p * neff});
    restart_flag = 1; start_i = 1;
    tick(1);
    start_i = 0; restart_flag = 0;
    if (flav & 2) begin
      src_drv[sel] = 1'b1;    // R5: before arm, must be ignored
      tick(2);
      src_drv[sel] = 1'b0;
    end
    while (!arm_o) tick(1);
    if (flav & 1) src_drv = src_drv | ~(4'b1 << sel); // R4
    if (dly > 0) tick(dly);
    src_drv[sel] = 1'b1;
    ct = rel + 1;
    s1 = ((ct + 4 + neff - 1) / neff) * neff - 1;
    sq = s1 + q * neff;
    exp_n = (sq + 1) / neff;
    exp_q.push_back('{EV_TRIG, ct + 3});
    exp_q.push_back('{EV_PW, s1 - ct - 2});
    exp_q.push_back('{EV_DONE, sq + 1});
    if (flav & 4) begin
      tick(3); src_drv[sel] = 1'b0;
      tick(2); src_drv[sel] = 1'b1; // R6: second edge ignored
      tick(1); start_i = 1;         // R9: start while running ignored
      tick(1); start_i = 0;
    end
    while (!done_o) tick(1);
    tick(2 * neff + 3);
    chk(done_o == 1'b1, "R9", done_o, 1);
    chk(trig_seen_o == 1'b1, "R9", trig_seen_o, 1);
    chk(arm_o == 1'b0, "R6", arm_o, 0);
    chk(interp_pulse_o == 1'b0, "R7", interp_pulse_o, 0);
    chk(nstb == exp_n, "R8", nstb, exp_n);
    chk(exp_q.size() == 0, "R5", exp_q.size(), 0);
    src_drv = '0;
  endtask

  initial begin
    #(8 * 150000);
    chk(0, "R8", 0, 1);
    $display("FAIL R8: watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    tick(3);
    chk({sample_en_o, arm_o, trig_seen_o, done_o, interp_pulse_o} == 5'b0, "R1",
        {sample_en_o, arm_o, trig_seen_o, done_o, interp_pulse_o}, 0);
    rst_ni = 1;
    tick(4);
    chk({sample_en_o, arm_o, trig_seen_o, done_o, interp_pulse_o} == 5'b0, "R1",
        {sample_en_o, arm_o, trig_seen_o, done_o, interp_pulse_o}, 0);
    run_case(1, 0, 0, 0, 0, 0); // strobe each cycle, pulse end and done coincide
    run_case(4, 3, 2, 1, 3, 1);
    run_case(5, 2, 0, 2, 1, 2);
    run_case(3, 1, 4, 3, 2, 4);
    run_case(0, 2, 1, 0, 0, 0); // ratio 0 acts as 1 (R2)
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule